// File: doc/BRIEF.md
# Program Counter Sequencer with High-Byte Latch

This block holds the 15-bit instruction address of a small processor with 8-bit data and 14-bit instruction words, and picks the next address every clock. The next address can come from a sequential step, the reset vector, the interrupt vector, an absolute jump or call target, a relative branch, a return address popped from an external call stack, or a software write to the low byte of the counter. The decoder that drives the operation code and the call stack that stores return addresses live outside the block. The stack is reached through a push-value output with a push strobe and a pop-value input.

Software sees two data-side registers. Reading the low-byte register returns the bottom eight bits of the counter. A separate 7-bit high-byte latch is written on its own and has no effect until software writes the low-byte register. At that moment the counter takes its upper seven bits from the latch and its lower eight bits from the written data. Absolute jumps and calls also take their upper four bits from the top of the latch.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, each clock edge sets `pc` to 0x0000 and the latch to 0x00. `push_en` stays low during reset.
- R2: When `irq_take` is high at a clock edge, `pc` becomes 0x0004. In that same cycle `push_en` is high and `push_val` equals the current `pc`. This overrides any operation, low-byte write or step.
- R3: When `advance` is high and no higher-priority source is active, `pc` becomes `pc+1`. The count wraps from 0x7FFF to 0x0000.
- R4: When no source is active (`advance` low, `op_kind` 0, no low-byte write, no interrupt), `pc` holds its value.
- R5: A data write to address 0x02 loads `pc` with `{latch[6:0], wdata[7:0]}`. The latch value used is the one held before that edge.
- R6: A data write to address 0x0A stores `wdata[6:0]` in the latch and leaves `pc` unchanged. Reads give `pc[7:0]` at address 0x02, `{0, latch}` at 0x0A, and 0 at any other address.
- R7: `op_kind` 1 (jump) loads `pc` with `{latch[6:3], op_imm[10:0]}` and does not push.
- R8: `op_kind` 2 (call) loads the same target as R7. In that cycle `push_en` is high and `push_val` is `pc+1`.
- R9: `op_kind` 3 (call through W) loads `pc` with `{latch[6:0], w_val[7:0]}`. In that cycle `push_en` is high and `push_val` is `pc+1`.
- R10: `op_kind` 4 (relative branch) loads `pc+1` plus the two's-complement value of `op_imm[8:0]`, taken modulo 2^15.
- R11: `op_kind` 5 (branch by W) loads `pc+1` plus `w_val` as an unsigned number, taken modulo 2^15.
- R12: `op_kind` 6 (return) loads `pc` from `pop_val`. Codes 0 and 7 start no operation.
- R13: Sources are ranked reset, then interrupt, then operation, then low-byte write, then step. A latch write done in the same cycle still updates the latch, but the operation uses the old latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_take | input | 1 | Take interrupt entry this cycle |
| advance | input | 1 | Step to the next sequential address |
| op_kind | input | 3 | Control-flow operation code (R7 to R12) |
| op_imm | input | 11 | Instruction literal: jump target or branch offset |
| w_val | input | 8 | Working register value for the W-based operations |
| pop_val | input | 15 | Return address from the call stack |
| dwr_en | input | 1 | Data-side write strobe |
| daddr | input | 7 | Data-side register address |
| dwdata | input | 8 | Data-side write data |
| drdata | output | 8 | Data-side read data |
| pc | output | 15 | Current program counter |
| push_en | output | 1 | Push a return address this cycle |
| push_val | output | 15 | Return address to push |

## Verification
The bench uses the default parameters: a 15-bit counter, an 11-bit jump literal, a 9-bit branch offset, and vectors 0x0000 and 0x0004. With these values the latch can set the counter to 0x7FFF, so the step wrap and a backward branch below zero can both be reached in a few cycles. The four jump bits taken from the latch can also be told apart from the three latch bits beneath them.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_JUMP    = 3'd1,
    OP_CALL    = 3'd2,
    OP_CALLW   = 3'd3,
    OP_BRANCH  = 3'd4,
    OP_BRANCHW = 3'd5,
    OP_RETURN  = 3'd6,
    OP_RSVD    = 3'd7
  } op_kind_e;

  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_INC  = 3'd1,
    SRC_LOW  = 3'd2,
    SRC_OP   = 3'd3,
    SRC_IRQ  = 3'd4,
    SRC_RST  = 3'd5
  } pc_src_e;

endpackage

// File: rtl/pcseq_latch.sv
module pcseq_latch #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int LATCH_W    = 7,
  parameter int LOW_ADDR   = 2,
  parameter int LATCH_ADDR = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  pc_low,
  output logic [LATCH_W-1:0] latch_q,
  output logic               low_wr,
  output logic               latch_wr,
  output logic [DATA_W-1:0]  rdata
);

  logic hit_low, hit_latch;
  assign hit_low   = (addr == ADDR_W'(LOW_ADDR));
  assign hit_latch = (addr == ADDR_W'(LATCH_ADDR));
  assign low_wr    = wr_en && hit_low;
  assign latch_wr  = wr_en && hit_latch;

  generate
    if (DATA_W > LATCH_W) begin : g_spare
      logic unused_wbits;
      assign unused_wbits = ^wdata[DATA_W-1:LATCH_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_wr) latch_q <= wdata[LATCH_W-1:0];
  end

  always_comb begin
    rdata = '0;
    if (hit_low)        rdata = pc_low;
    else if (hit_latch) rdata = DATA_W'(latch_q);
  end

  // R6: the latch captures the written bits one edge later
  a_r6_latch_capture: assert property (@(posedge clk) disable iff (!rst_n)
    latch_wr |=> latch_q == $past(wdata[LATCH_W-1:0]));

  // R6: without a write the latch keeps its value
  a_r6_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_wr |=> $stable(latch_q));

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
  import pcseq_pkg::*;
#(
  parameter int PC_W    = 15,
  parameter int DATA_W  = 8,
  parameter int LATCH_W = 7,
  parameter int IMM_W   = 11,
  parameter int BR_W    = 9
) (
  input  logic [PC_W-1:0]    pc_q,
  input  logic [LATCH_W-1:0] latch_q,
  input  op_kind_e           op,
  input  logic [IMM_W-1:0]   imm,
  input  logic [DATA_W-1:0]  w_val,
  input  logic [PC_W-1:0]    pop_val,
  output logic               op_load,
  output logic [PC_W-1:0]    op_target,
  output logic               op_push,
  output logic [PC_W-1:0]    ret_addr
);

  localparam int HI_W = PC_W - IMM_W;

  function automatic logic [PC_W-1:0] f_step(input logic [PC_W-1:0] a);
    return a + PC_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] f_abs(input logic [LATCH_W-1:0] l,
                                            input logic [IMM_W-1:0] k);
    return {l[LATCH_W-1 -: HI_W], k};
  endfunction

  function automatic logic [PC_W-1:0] f_pair(input logic [LATCH_W-1:0] l,
                                             input logic [DATA_W-1:0] b);
    return {l, b};
  endfunction

  function automatic logic [PC_W-1:0] f_rel_signed(input logic [PC_W-1:0] base,
                                                   input logic [BR_W-1:0] off);
    return base + {{(PC_W-BR_W){off[BR_W-1]}}, off};
  endfunction

  function automatic logic [PC_W-1:0] f_rel_unsigned(input logic [PC_W-1:0] base,
                                                     input logic [DATA_W-1:0] off);
    return base + PC_W'(off);
  endfunction

  logic [PC_W-1:0] next_seq;
  assign next_seq = f_step(pc_q);
  assign ret_addr = next_seq;

  always_comb begin
    op_load   = 1'b1;
    op_push   = 1'b0;
    op_target = pc_q;
    unique case (op)
      OP_JUMP:    op_target = f_abs(latch_q, imm);
      OP_CALL:    begin op_target = f_abs(latch_q, imm); op_push = 1'b1; end
      OP_CALLW:   begin op_target = f_pair(latch_q, w_val); op_push = 1'b1; end
      OP_BRANCH:  op_target = f_rel_signed(next_seq, imm[BR_W-1:0]);
      OP_BRANCHW: op_target = f_rel_unsigned(next_seq, w_val);
      OP_RETURN:  op_target = pop_val;
      default:    op_load = 1'b0;
    endcase
  end

  // R8 / R9: only the two call forms request a push
  a_r8_push_calls_only: assert final (!op_push || op == OP_CALL || op == OP_CALLW);

endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
  import pcseq_pkg::*;
#(
  parameter int PC_W      = 15,
  parameter int RESET_VEC = 0,
  parameter int IRQ_VEC   = 4
) (
  input  logic            rst_n,
  input  logic            irq_take,
  input  logic            op_load,
  input  logic [PC_W-1:0] op_target,
  input  logic            low_wr,
  input  logic [PC_W-1:0] low_target,
  input  logic            advance,
  input  logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] pc_next,
  output pc_src_e         src
);

  always_comb begin
    if (!rst_n)        src = SRC_RST;
    else if (irq_take) src = SRC_IRQ;
    else if (op_load)  src = SRC_OP;
    else if (low_wr)   src = SRC_LOW;
    else if (advance)  src = SRC_INC;
    else               src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_RST: pc_next = PC_W'(RESET_VEC);
      SRC_IRQ: pc_next = PC_W'(IRQ_VEC);
      SRC_OP:  pc_next = op_target;
      SRC_LOW: pc_next = low_target;
      SRC_INC: pc_next = pc_q + PC_W'(1);
      default: pc_next = pc_q;
    endcase
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PC_W       = 15,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 7,
  parameter int IMM_W      = 11,
  parameter int BR_W       = 9,
  parameter int RESET_VEC  = 0,
  parameter int IRQ_VEC    = 4,
  parameter int LOW_ADDR   = 2,
  parameter int LATCH_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_take,
  input  logic              advance,
  input  logic [2:0]        op_kind,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic [DATA_W-1:0] w_val,
  input  logic [PC_W-1:0]   pop_val,
  input  logic              dwr_en,
  input  logic [ADDR_W-1:0] daddr,
  input  logic [DATA_W-1:0] dwdata,
  output logic [DATA_W-1:0] drdata,
  output logic [PC_W-1:0]   pc,
  output logic              push_en,
  output logic [PC_W-1:0]   push_val
);

  localparam int LATCH_W = PC_W - DATA_W;

  logic [PC_W-1:0]    pc_q, pc_next, op_target, ret_addr, low_target;
  logic [LATCH_W-1:0] latch_q;
  logic               low_wr, latch_wr, op_load, op_push;
  op_kind_e           op;
  pc_src_e            src;

  assign op = op_kind_e'(op_kind);

  pcseq_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LATCH_W(LATCH_W),
    .LOW_ADDR(LOW_ADDR), .LATCH_ADDR(LATCH_ADDR)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(dwr_en), .addr(daddr), .wdata(dwdata),
    .pc_low(pc_q[DATA_W-1:0]), .latch_q(latch_q), .low_wr(low_wr),
    .latch_wr(latch_wr), .rdata(drdata)
  );

  pcseq_target #(
    .PC_W(PC_W), .DATA_W(DATA_W), .LATCH_W(LATCH_W), .IMM_W(IMM_W), .BR_W(BR_W)
  ) u_target (
    .pc_q(pc_q), .latch_q(latch_q), .op(op), .imm(op_imm), .w_val(w_val),
    .pop_val(pop_val), .op_load(op_load), .op_target(op_target),
    .op_push(op_push), .ret_addr(ret_addr)
  );

  assign low_target = {latch_q, dwdata};

  pcseq_select #(
    .PC_W(PC_W), .RESET_VEC(RESET_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_select (
    .rst_n(rst_n), .irq_take(irq_take), .op_load(op_load), .op_target(op_target),
    .low_wr(low_wr), .low_target(low_target), .advance(advance), .pc_q(pc_q),
    .pc_next(pc_next), .src(src)
  );

  always_ff @(posedge clk) pc_q <= pc_next;

  assign pc       = pc_q;
  assign push_en  = (src == SRC_IRQ) || (src == SRC_OP && op_push);
  assign push_val = (src == SRC_IRQ) ? pc_q : ret_addr;

  // R1: reset clears the counter on the following edge
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> pc_q == PC_W'(RESET_VEC));

  // R1: no push request during reset
  a_r1_no_push_in_reset: assert property (@(posedge clk)
    !rst_n |-> !push_en);

  // R2: interrupt entry reaches the vector and saves the current address
  a_r2_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> pc_q == PC_W'(IRQ_VEC));
  a_r2_irq_push: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (push_en && push_val == pc_q));

  // R3: a lone step moves the counter by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !irq_take && !op_load && !low_wr) |=> pc_q == $past(pc_q) + PC_W'(1));

  // R4 / R6: with no source active, and across a latch write alone, the counter holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !irq_take && !op_load && !low_wr) |=> $stable(pc_q));

  // R5: a low-byte write joins the old latch with the data
  a_r5_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    (low_wr && !irq_take && !op_load) |=> pc_q == {$past(latch_q), $past(dwdata)});

  // R12: return takes the popped address
  a_r12_return: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RETURN && !irq_take) |=> pc_q == $past(pop_val));

  // R8: pushes only come from interrupts or calls
  a_r8_push_source: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (irq_take || op == OP_CALL || op == OP_CALLW));

endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n, irq_take, advance, dwr_en;
  logic [2:0]  op_kind;
  logic [10:0] op_imm;
  logic [7:0]  w_val, dwdata, drdata;
  logic [6:0]  daddr;
  logic [14:0] pop_val, pc, push_val;
  logic        push_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .advance(advance),
    .op_kind(op_kind), .op_imm(op_imm), .w_val(w_val), .pop_val(pop_val),
    .dwr_en(dwr_en), .daddr(daddr), .dwdata(dwdata), .drdata(drdata),
    .pc(pc), .push_en(push_en), .push_val(push_val)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    irq_take = 0; advance = 0; op_kind = 0; op_imm = 0; w_val = 0;
    pop_val = 0; dwr_en = 0; daddr = 0; dwdata = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic dwrite(input logic [6:0] a, input logic [7:0] d);
    idle(); dwr_en = 1; daddr = a; dwdata = d; tick(); idle();
  endtask

  task automatic set_pc(input logic [14:0] v);
    dwrite(7'h0A, {1'b0, v[14:8]});
    dwrite(7'h02, v[7:0]);
  endtask

  task automatic t_reset();
    idle(); rst_n = 0; tick(); tick();
    check("R1", pc, 0, "pc in reset");
    check("R1", push_en, 0, "push_en in reset");
    daddr = 7'h0A; #1;
    check("R1", drdata, 0, "latch in reset");
    rst_n = 1; idle(); tick();
    check("R4", pc, 0, "hold after reset");
  endtask

  task automatic t_step();
    idle(); advance = 1; tick(); tick(); tick();
    check("R3", pc, 3, "three steps");
    idle(); tick(); tick();
    check("R4", pc, 3, "hold without advance");
    op_kind = 7; tick(); idle();
    check("R12", pc, 3, "reserved code is no operation");
  endtask

  task automatic t_latch_regs();
    logic [14:0] p;
    p = pc;
    dwrite(7'h0A, 8'hD5);
    check("R6", pc, p, "latch write leaves pc");
    daddr = 7'h0A; #1;
    check("R6", drdata, 8'h55, "latch readback");
    daddr = 7'h02; #1;
    check("R6", drdata, p & 8'hFF, "low byte readback");
    daddr = 7'h05; #1;
    check("R6", drdata, 0, "unmapped read");
    idle();
  endtask

  task automatic t_low_write();
    dwrite(7'h02, 8'h3C);
    check("R5", pc, 15'h553C, "low write joins latch");
    set_pc(15'h7FFF);
    check("R5", pc, 15'h7FFF, "low write with full latch");
    advance = 1; tick(); idle();
    check("R3", pc, 0, "step wraps to zero");
  endtask

  task automatic t_jump_call();
    logic [14:0] p;
    dwrite(7'h0A, 8'h55);
    op_kind = 1; op_imm = 11'h123; #1;
    check("R7", push_en, 0, "jump does not push");
    tick(); idle();
    check("R7", pc, (4'hA << 11) | 11'h123, "jump target");
    p = pc;
    op_kind = 2; op_imm = 11'h7FF; #1;
    check("R8", push_en, 1, "call push strobe");
    check("R8", push_val, (p + 1) & 15'h7FFF, "call return address");
    tick(); idle();
    check("R8", pc, (4'hA << 11) | 11'h7FF, "call target");
    p = pc;
    op_kind = 3; w_val = 8'h9A; #1;
    check("R9", push_en, 1, "callw push strobe");
    check("R9", push_val, (p + 1) & 15'h7FFF, "callw return address");
    tick(); idle();
    check("R9", pc, (15'h55 << 8) | 8'h9A, "callw target");
  endtask

  function automatic int rel_exp(input int p, input int off9);
    int s;
    s = (off9 >= 256) ? off9 - 512 : off9;
    return (p + 1 + s + 32768) % 32768;
  endfunction

  task automatic t_branch();
    logic [14:0] p;
    p = pc;
    op_kind = 4; op_imm = 11'h1F0; tick(); idle();
    check("R10", pc, rel_exp(p, 9'h1F0), "backward branch");
    p = pc;
    op_kind = 4; op_imm = 11'h605; tick(); idle();
    check("R10", pc, rel_exp(p, 9'h005), "forward branch ignores upper literal bits");
    set_pc(15'h0000);
    op_kind = 4; op_imm = 11'h1FE; tick(); idle();
    check("R10", pc, 15'h7FFF, "branch wraps below zero");
    p = pc;
    op_kind = 5; w_val = 8'hF0; tick(); idle();
    check("R11", pc, (p + 1 + 240) % 32768, "branch by W wraps");
    p = pc;
    op_kind = 5; w_val = 8'h10; tick(); idle();
    check("R11", pc, (p + 1 + 16) % 32768, "branch by W forward");
  endtask

  task automatic t_return();
    op_kind = 6; pop_val = 15'h1234; #1;
    check("R12", push_en, 0, "return does not push");
    tick(); idle();
    check("R12", pc, 15'h1234, "return address");
  endtask

  task automatic t_irq();
    logic [14:0] p;
    p = pc;
    irq_take = 1; op_kind = 1; op_imm = 11'h055; advance = 1; #1;
    check("R2", push_en, 1, "irq push strobe");
    check("R2", push_val, p, "irq saves current pc");
    tick(); idle();
    check("R2", pc, 4, "irq vector wins");
  endtask

  task automatic t_priority();
    dwrite(7'h0A, 8'h00);
    op_kind = 1; op_imm = 11'h321; dwr_en = 1; daddr = 7'h02; dwdata = 8'hAA; advance = 1;
    tick(); idle();
    check("R13", pc, 15'h0321, "operation over low write");
    dwr_en = 1; daddr = 7'h02; dwdata = 8'h77; advance = 1; tick(); idle();
    check("R13", pc, 15'h0077, "low write over step");
    op_kind = 1; op_imm = 11'h011; dwr_en = 1; daddr = 7'h0A; dwdata = 8'h7F;
    tick(); idle();
    check("R13", pc, 15'h0011, "jump uses old latch");
    daddr = 7'h0A; #1;
    check("R13", drdata, 8'h7F, "latch still written");
    idle();
    rst_n = 0; irq_take = 1; advance = 1; tick(); rst_n = 1; idle();
    check("R1", pc, 0, "reset over interrupt");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    #2;
    t_reset();
    t_step();
    t_latch_regs();
    t_low_write();
    t_jump_call();
    t_branch();
    t_return();
    t_irq();
    t_priority();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule